// File: doc/BRIEF.md
# Parallel Window Index Generator

This block expands one centre cell of a regular two-dimensional grid into the grid indices of every cell in a square window of side `WIN` around it. Each output beat carries `LANES` cells side by side, one per parallel processing lane. A centre therefore takes ceil(WIN*WIN/LANES) beats. For every cell the block also computes a fixed-point coordinate, the index times a per-axis step plus a per-axis origin, so that downstream kernel units receive ready-to-use operands.

The centre arrives on a valid/ready handshake. The lanes leave together on a second valid/ready handshake, and a low downstream ready freezes all of them at once. A lane whose cell lies past the end of the window, or off the grid, has its valid bit cleared. Its index is reported unwrapped. Window size, lane count, grid extent, coordinate width, steps and origins are all elaboration parameters.

Top module: `win_index_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_vld` is low and `cen_rdy` is high.
- R2: Every accepted centre yields exactly NGRP = ceil(WIN*WIN/LANES) output beats, in order. `out_last` is high on the final beat only.
- R3: Cells are numbered c = g*LANES + l, where g is the beat number and l is the lane. Within the window the x offset advances fastest and the y offset next. Lane l carries x index = cx + (c mod WIN) - H and y index = cy + (c div WIN) - H, with H = (WIN-1)/2. It is two's complement in bits [l*SIW +: SIW] of `lane_xi`/`lane_yi`.
- R4: Lanes whose cell number c is WIN*WIN or more have their `lane_vld` bit low. Only the final beat can hold such lanes.
- R5: A lane inside the window has `lane_vld` high exactly when 0 <= x index < GRID_NX and 0 <= y index < GRID_NY. Out-of-grid indices are reported unwrapped.
- R6: Bits [l*CRD_W +: CRD_W] of `lane_xc` equal x index * X_STEP + X_ORG, and those of `lane_yc` equal y index * Y_STEP + Y_ORG. Both are truncated to CRD_W bits, two's complement.
- R7: When `out_vld` is high and `out_rdy` is low, every output holds its value on the next cycle.
- R8: While a centre still has beats other than its last to issue, `cen_rdy` is low. A new centre is taken in the same cycle the previous last beat issues, so back-to-back centres stream with no idle beat while `out_rdy` stays high.
- R9: With the output pipeline empty, the first beat of a centre accepted at clock edge E is on the outputs after edge E+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cen_vld | input | 1 | Centre offered |
| cen_rdy | output | 1 | Centre can be taken this cycle |
| cen_x | input | CXW | Centre column index |
| cen_y | input | CYW | Centre row index |
| out_rdy | input | 1 | Downstream accepts the current beat |
| out_vld | output | 1 | Beat present on the lanes |
| out_last | output | 1 | Final beat of the current centre |
| lane_vld | output | LANES | Per-lane cell valid (in window and on grid) |
| lane_xi | output | LANES*SIW | Per-lane signed x index |
| lane_yi | output | LANES*SIW | Per-lane signed y index |
| lane_xc | output | LANES*CRD_W | Per-lane x coordinate |
| lane_yc | output | LANES*CRD_W | Per-lane y coordinate |

## Verification
Two builds run side by side. The first has a 3-wide window over four lanes on an 8 by 6 grid: nine cells over three beats, a single live lane in the last beat, and column carries inside a beat. The second has a 2-wide window over five lanes on a 5 by 4 grid, so the lanes outnumber the cells and each centre is one beat. In each build every grid cell is used as a centre twice, once with a steady downstream and once with random back-pressure and input gaps. This covers all window edges that fall off the grid, negative coordinates and stalls on every beat position.

// File: rtl/wig_pkg.sv
`timescale 1ns/1ps
package wig_pkg;
  // ceiling of a / b for positive operands
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // bits needed to hold the values 0 .. v-1, at least one
  function automatic int wbits(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/wig_seq.sv
`timescale 1ns/1ps
// Beat sequencer: holds the current centre and the window position of lane 0.
module wig_seq
  import wig_pkg::*;
#(
  parameter int WIN   = 5,
  parameter int LANES = 8,
  parameter int CXW   = 8,
  parameter int CYW   = 8,
  parameter int OW    = wbits(WIN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  input  logic           cen_vld,
  input  logic [CXW-1:0] cen_x,
  input  logic [CYW-1:0] cen_y,
  output logic           cen_rdy,
  output logic           grp_vld,
  output logic           grp_last,
  output logic [CXW-1:0] cur_x,
  output logic [CYW-1:0] cur_y,
  output logic [OW-1:0]  base_col,
  output logic [OW-1:0]  base_row
);
  localparam int CELLS    = WIN * WIN;
  localparam int NGRP     = cdiv(CELLS, LANES);
  localparam int GW       = wbits(NGRP);
  localparam int COL_STEP = LANES % WIN;
  localparam int ROW_STEP = LANES / WIN;

  logic          busy_q;
  logic [GW-1:0] grp_q;
  logic [OW-1:0] col_q, row_q;
  logic          last_g, issue, load, wrap;
  logic [OW:0]   colsum;
  logic [OW-1:0] col_n, row_n;

  assign last_g  = (grp_q == GW'(NGRP - 1));
  assign issue   = busy_q & adv;
  assign cen_rdy = ~busy_q | (last_g & adv);
  assign load    = cen_vld & cen_rdy;

  // lane-0 position of the next beat: step by LANES cells, carry into the row
  always_comb begin
    colsum = {1'b0, col_q} + (OW+1)'(COL_STEP);
    wrap   = (colsum >= (OW+1)'(WIN));
    col_n  = wrap ? OW'(colsum - (OW+1)'(WIN)) : OW'(colsum);
    row_n  = row_q + OW'(ROW_STEP) + OW'(wrap);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      grp_q  <= '0;
      col_q  <= '0;
      row_q  <= '0;
      cur_x  <= '0;
      cur_y  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      grp_q  <= '0;
      col_q  <= '0;
      row_q  <= '0;
      cur_x  <= cen_x;
      cur_y  <= cen_y;
    end else if (issue) begin
      if (last_g) begin
        busy_q <= 1'b0;
      end else begin
        grp_q <= grp_q + GW'(1);
        col_q <= col_n;
        row_q <= row_n;
      end
    end
  end

  assign grp_vld  = busy_q;
  assign grp_last = last_g;
  assign base_col = col_q;
  assign base_row = row_q;

  // R2: the beat counter never passes the last beat of a centre
  assert_grp_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (int'(grp_q) < NGRP));

  // R3: lane-0 column stays inside the window
  assert_col_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (int'(col_q) < WIN));

  // R8: a centre is taken while busy only when its last beat leaves
  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last_g) |=> $stable(cur_x) && $stable(cur_y));
endmodule

// File: rtl/wig_lane.sv
`timescale 1ns/1ps
// One lane: resolves its window cell from the lane-0 position and registers
// the signed grid index with its in-window and on-grid flags.
module wig_lane
  import wig_pkg::*;
#(
  parameter int LANE = 0,
  parameter int WIN  = 5,
  parameter int NX   = 256,
  parameter int NY   = 256,
  parameter int CXW  = 8,
  parameter int CYW  = 8,
  parameter int OW   = wbits(WIN + 1),
  parameter int SIW  = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [OW-1:0]         base_col,
  input  logic [OW-1:0]         base_row,
  input  logic [CXW-1:0]        cur_x,
  input  logic [CYW-1:0]        cur_y,
  output logic                  win_q,
  output logic                  vld_q,
  output logic signed [SIW-1:0] xi_q,
  output logic signed [SIW-1:0] yi_q
);
  localparam int LC = LANE % WIN;
  localparam int LR = LANE / WIN;
  localparam int H  = (WIN - 1) / 2;

  logic [OW:0] csum;
  logic        wr, in_win, on_grid;
  int          col_i, row_i, xi_i, yi_i;

  always_comb begin
    csum    = {1'b0, base_col} + (OW+1)'(LC);
    wr      = (csum >= (OW+1)'(WIN));
    col_i   = wr ? int'(csum) - WIN : int'(csum);
    row_i   = int'(base_row) + LR + int'(wr);
    in_win  = (row_i < WIN);
    xi_i    = int'(cur_x) + col_i - H;
    yi_i    = int'(cur_y) + row_i - H;
    on_grid = (xi_i >= 0) && (xi_i < NX) && (yi_i >= 0) && (yi_i < NY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= 1'b0;
      vld_q <= 1'b0;
      xi_q  <= '0;
      yi_q  <= '0;
    end else if (en) begin
      win_q <= in_win;
      vld_q <= in_win & on_grid;
      xi_q  <= SIW'(xi_i);
      yi_q  <= SIW'(yi_i);
    end
  end

  // R5: a valid lane always points inside the grid
  assert_on_grid_R5: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (int'(xi_q) >= 0 && int'(xi_q) < NX && int'(yi_q) >= 0 && int'(yi_q) < NY));

  // R4: a lane outside the window is never valid
  assert_win_gate_R4: assert property (@(posedge clk) disable iff (rst)
    !win_q |-> !vld_q);
endmodule

// File: rtl/wig_coord.sv
`timescale 1ns/1ps
// Index to fixed-point coordinate: idx * STEP + ORG, one register stage.
module wig_coord #(
  parameter int SIW   = 10,
  parameter int CRD_W = 32,
  parameter int STEP  = 256,
  parameter int ORG   = 0
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic signed [SIW-1:0]   idx,
  output logic signed [CRD_W-1:0] crd
);
  localparam logic signed [CRD_W-1:0] STEP_C = CRD_W'(STEP);
  localparam logic signed [CRD_W-1:0] ORG_C  = CRD_W'(ORG);

  logic signed [CRD_W-1:0] idx_w;
  assign idx_w = CRD_W'(idx);

  always_ff @(posedge clk) begin
    if (en) crd <= idx_w * STEP_C + ORG_C;
  end
endmodule

// File: rtl/win_index_gen.sv
`timescale 1ns/1ps
module win_index_gen
  import wig_pkg::*;
#(
  parameter int WIN     = 5,
  parameter int LANES   = 8,
  parameter int GRID_NX = 256,
  parameter int GRID_NY = 256,
  parameter int CRD_W   = 32,
  parameter int X_STEP  = 256,
  parameter int Y_STEP  = 256,
  parameter int X_ORG   = 0,
  parameter int Y_ORG   = 0,
  localparam int CXW    = wbits(GRID_NX),
  localparam int CYW    = wbits(GRID_NY),
  localparam int NMAX   = (GRID_NX > GRID_NY) ? GRID_NX : GRID_NY,
  localparam int SIW    = $clog2(NMAX + WIN) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cen_vld,
  output logic                   cen_rdy,
  input  logic [CXW-1:0]         cen_x,
  input  logic [CYW-1:0]         cen_y,
  input  logic                   out_rdy,
  output logic                   out_vld,
  output logic                   out_last,
  output logic [LANES-1:0]       lane_vld,
  output logic [LANES*SIW-1:0]   lane_xi,
  output logic [LANES*SIW-1:0]   lane_yi,
  output logic [LANES*CRD_W-1:0] lane_xc,
  output logic [LANES*CRD_W-1:0] lane_yc
);
  localparam int OW     = wbits(WIN + 1);
  localparam int CELLS  = WIN * WIN;
  localparam int NGRP   = cdiv(CELLS, LANES);
  localparam int GW     = wbits(NGRP);
  localparam int LAST_N = CELLS - (NGRP - 1) * LANES;

  logic           adv;
  logic           grp_vld, grp_last;
  logic [CXW-1:0] cur_x;
  logic [CYW-1:0] cur_y;
  logic [OW-1:0]  base_col, base_row;
  logic           s1_vld, s1_last, s2_vld, s2_last;
  logic [LANES-1:0] s2_win;

  // whole pipeline moves together; it stops only with a held beat at the edge
  assign adv = ~s2_vld | out_rdy;

  wig_seq #(
    .WIN(WIN), .LANES(LANES), .CXW(CXW), .CYW(CYW), .OW(OW)
  ) u_seq (
    .clk(clk), .rst(rst), .adv(adv),
    .cen_vld(cen_vld), .cen_x(cen_x), .cen_y(cen_y), .cen_rdy(cen_rdy),
    .grp_vld(grp_vld), .grp_last(grp_last),
    .cur_x(cur_x), .cur_y(cur_y), .base_col(base_col), .base_row(base_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_last <= 1'b0;
      s2_vld  <= 1'b0;
      s2_last <= 1'b0;
    end else if (adv) begin
      s1_vld  <= grp_vld;
      s1_last <= grp_vld & grp_last;
      s2_vld  <= s1_vld;
      s2_last <= s1_last;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic                    win1, ok1, win2, ok2;
    logic signed [SIW-1:0]   xi1, yi1, xi2, yi2;
    logic signed [CRD_W-1:0] xc2, yc2;

    wig_lane #(
      .LANE(g), .WIN(WIN), .NX(GRID_NX), .NY(GRID_NY),
      .CXW(CXW), .CYW(CYW), .OW(OW), .SIW(SIW)
    ) u_lane (
      .clk(clk), .rst(rst), .en(adv),
      .base_col(base_col), .base_row(base_row), .cur_x(cur_x), .cur_y(cur_y),
      .win_q(win1), .vld_q(ok1), .xi_q(xi1), .yi_q(yi1)
    );

    wig_coord #(.SIW(SIW), .CRD_W(CRD_W), .STEP(X_STEP), .ORG(X_ORG)) u_xc (
      .clk(clk), .en(adv), .idx(xi1), .crd(xc2)
    );

    wig_coord #(.SIW(SIW), .CRD_W(CRD_W), .STEP(Y_STEP), .ORG(Y_ORG)) u_yc (
      .clk(clk), .en(adv), .idx(yi1), .crd(yc2)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        win2 <= 1'b0;
        ok2  <= 1'b0;
        xi2  <= '0;
        yi2  <= '0;
      end else if (adv) begin
        win2 <= win1;
        ok2  <= ok1;
        xi2  <= xi1;
        yi2  <= yi1;
      end
    end

    assign s2_win[g]                   = win2;
    assign lane_vld[g]                 = ok2;
    assign lane_xi[g*SIW +: SIW]       = xi2;
    assign lane_yi[g*SIW +: SIW]       = yi2;
    assign lane_xc[g*CRD_W +: CRD_W]   = xc2;
    assign lane_yc[g*CRD_W +: CRD_W]   = yc2;
  end

  assign out_vld  = s2_vld;
  assign out_last = s2_last;

  // beat counter seen from the output side, for the beat-count checks
  logic [GW-1:0] out_cnt;
  always_ff @(posedge clk) begin
    if (rst)                   out_cnt <= '0;
    else if (out_vld && out_rdy) out_cnt <= out_last ? '0 : out_cnt + GW'(1);
  end

  // R1: reset empties the output
  assert_reset_R1: assert property (@(posedge clk) rst |=> !out_vld);

  // R2: the last beat is exactly the NGRP-th of its centre
  assert_count_R2: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_last) |-> (int'(out_cnt) == NGRP - 1));

  assert_count_mid_R2: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_last) |-> (int'(out_cnt) < NGRP - 1));

  // R4: full beats carry LANES window cells, the last beat carries the rest
  assert_mask_R4: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ($countones(s2_win) == (out_last ? LAST_N : LANES)));

  // R7: a refused beat is held unchanged
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_rdy) |=> out_vld && $stable(out_last) && $stable(lane_vld)
      && $stable(lane_xi) && $stable(lane_yi) && $stable(lane_xc) && $stable(lane_yc));
endmodule

// File: tb/win_index_gen_test.sv
`timescale 1ns/1ps
// One build of the block with its own driver, scoreboard and counters.
module wig_harness #(
  parameter int WIN   = 3,
  parameter int LANES = 4,
  parameter int NX    = 8,
  parameter int NY    = 6,
  parameter int DX    = 40,
  parameter int DY    = -24,
  parameter int X0    = 1000,
  parameter int Y0    = -300,
  parameter int CRD_W = 20
) (
  input  logic clk,
  output logic done
);
  localparam int CELLS = WIN * WIN;
  localparam int NGRP  = (CELLS + LANES - 1) / LANES;
  localparam int H     = (WIN - 1) / 2;
  localparam int CXW   = (NX <= 2) ? 1 : $clog2(NX);
  localparam int CYW   = (NY <= 2) ? 1 : $clog2(NY);
  localparam int NMAX  = (NX > NY) ? NX : NY;
  localparam int SIW   = $clog2(NMAX + WIN) + 1;

  logic rst = 1'b1, cen_vld = 1'b0, out_rdy = 1'b1;
  logic [CXW-1:0] cen_x = '0;
  logic [CYW-1:0] cen_y = '0;
  logic cen_rdy, out_vld, out_last;
  logic [LANES-1:0]       lane_vld;
  logic [LANES*SIW-1:0]   lane_xi, lane_yi;
  logic [LANES*CRD_W-1:0] lane_xc, lane_yc;

  win_index_gen #(
    .WIN(WIN), .LANES(LANES), .GRID_NX(NX), .GRID_NY(NY), .CRD_W(CRD_W),
    .X_STEP(DX), .Y_STEP(DY), .X_ORG(X0), .Y_ORG(Y0)
  ) uut (
    .clk(clk), .rst(rst), .cen_vld(cen_vld), .cen_rdy(cen_rdy),
    .cen_x(cen_x), .cen_y(cen_y), .out_rdy(out_rdy), .out_vld(out_vld),
    .out_last(out_last), .lane_vld(lane_vld), .lane_xi(lane_xi),
    .lane_yi(lane_yi), .lane_xc(lane_xc), .lane_yc(lane_yc)
  );

  int npass = 0, nfail = 0;
  int cyc = 0, acc_n = 0, rd_i = 0, rd_g = 0, nout = 0;
  int qx[0:255], qy[0:255], acc_at[0:255];
  bit lat_chk = 0, meas = 0, rnd = 0;
  int first_b = -1, last_b = -1, cnt_b = 0;
  bit hold_pend = 0;
  logic [LANES-1:0] s_vld;
  logic s_last;
  logic [LANES*SIW-1:0]   s_xi, s_yi;
  logic [LANES*CRD_W-1:0] s_xc, s_yc;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    if (ok) npass++;
    else begin
      nfail++;
      $display("FAIL %s %s (WIN=%0d LANES=%0d): actual %0d expected %0d",
               req, what, WIN, LANES, act, exp);
    end
  endtask

  // downstream ready: steady or random, changed just after each edge
  always @(posedge clk) begin
    #1;
    out_rdy = rnd ? ($urandom % 3 != 0) : 1'b1;
  end

  // scoreboard, sampled mid-cycle
  always @(negedge clk) begin
    int  c, ex, ey;
    bit  w, ev;
    int  ax, ay;
    logic [CRD_W-1:0] ecx, ecy, acx, acy;
    cyc++;
    if (!rst) begin
      if (hold_pend) begin
        chk(out_vld && out_last == s_last && lane_vld == s_vld && lane_xi == s_xi
            && lane_yi == s_yi && lane_xc == s_xc && lane_yc == s_yc,
            "R7", "outputs held under stall", longint'(out_vld), 1);
      end
      hold_pend = out_vld && !out_rdy;
      if (hold_pend) begin
        s_vld = lane_vld; s_last = out_last; s_xi = lane_xi; s_yi = lane_yi;
        s_xc = lane_xc; s_yc = lane_yc;
      end
      if (cen_vld && cen_rdy) begin
        qx[acc_n] = int'(cen_x);
        qy[acc_n] = int'(cen_y);
        acc_at[acc_n] = cyc;
        acc_n++;
      end
      if (out_vld && out_rdy) begin
        if (rd_i >= acc_n) begin
          chk(0, "R2", "beat with no centre pending", rd_i, acc_n);
        end else begin
          if (rd_g == 0 && lat_chk)
            chk(cyc - acc_at[rd_i] == 3, "R9", "first-beat latency", cyc - acc_at[rd_i], 3);
          for (int l = 0; l < LANES; l++) begin
            c  = rd_g * LANES + l;
            w  = (c < CELLS);
            ex = qx[rd_i] + (c % WIN) - H;
            ey = qy[rd_i] + (c / WIN) - H;
            ev = w && ex >= 0 && ex < NX && ey >= 0 && ey < NY;
            chk(lane_vld[l] == ev, w ? "R5" : "R4", "lane valid", longint'(lane_vld[l]), longint'(ev));
            if (w) begin
              ax  = int'($signed(lane_xi[l*SIW +: SIW]));
              ay  = int'($signed(lane_yi[l*SIW +: SIW]));
              chk(ax == ex, "R3", "x index", ax, ex);
              chk(ay == ey, "R3", "y index", ay, ey);
              ecx = CRD_W'(ex * DX + X0);
              ecy = CRD_W'(ey * DY + Y0);
              acx = lane_xc[l*CRD_W +: CRD_W];
              acy = lane_yc[l*CRD_W +: CRD_W];
              chk(acx == ecx, "R6", "x coordinate", longint'(acx), longint'(ecx));
              chk(acy == ecy, "R6", "y coordinate", longint'(acy), longint'(ecy));
            end
          end
          chk(out_last == (rd_g == NGRP - 1), "R2", "last-beat flag",
              longint'(out_last), longint'(rd_g == NGRP - 1));
          if (rd_g == NGRP - 1) begin rd_i++; rd_g = 0; end
          else rd_g++;
        end
        nout++;
        if (meas) begin
          if (first_b < 0) first_b = cyc;
          last_b = cyc;
          cnt_b++;
        end
      end
    end
  end

  // called just after an edge; returns just after the accepting edge
  task automatic send(input int x, input int y);
    cen_x = CXW'(x);
    cen_y = CYW'(y);
    cen_vld = 1'b1;
    @(negedge clk);
    while (!cen_rdy) @(negedge clk);
    @(posedge clk);
    #1;
    cen_vld = 1'b0;
  endtask

  task automatic drain();
    while (rd_i < acc_n) begin
      @(posedge clk);
      #1;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_vld && cen_rdy, "R1", "idle during reset", longint'({out_vld, cen_rdy}), 1);
    @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    chk(!out_vld, "R1", "out_vld after reset", longint'(out_vld), 0);
    chk(cen_rdy, "R1", "cen_rdy after reset", longint'(cen_rdy), 1);
    chk(lane_vld == '0, "R1", "lane_vld after reset", longint'(lane_vld), 0);
    @(posedge clk);
    #1;

    // single centre into an empty pipe: latency and input back-pressure
    lat_chk = 1;
    send(1, 1);
    @(negedge clk);
    chk(cen_rdy == (NGRP == 1), "R8", "cen_rdy while beats remain",
        longint'(cen_rdy), longint'(NGRP == 1));
    @(posedge clk);
    #1;
    drain();
    lat_chk = 0;

    // every centre, steady downstream: gapless stream
    meas = 1;
    for (int y = 0; y < NY; y++)
      for (int x = 0; x < NX; x++)
        send(x, y);
    drain();
    meas = 0;
    chk(last_b - first_b + 1 == NX * NY * NGRP, "R8", "gapless stream span",
        last_b - first_b + 1, NX * NY * NGRP);
    chk(cnt_b == NX * NY * NGRP, "R2", "beats in sweep", cnt_b, NX * NY * NGRP);

    // every centre again, random back-pressure and input gaps
    rnd = 1;
    for (int y = NY - 1; y >= 0; y--)
      for (int x = 0; x < NX; x++) begin
        send(x, y);
        if ($urandom % 2 == 0) begin @(posedge clk); #1; end
      end
    drain();
    rnd = 0;
    chk(nout == acc_n * NGRP, "R2", "total beats", nout, acc_n * NGRP);
    done = 1'b1;
  end
endmodule

module win_index_gen_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic done_a, done_b;
  bit   timed_out = 0;

  // three-wide window over four lanes: partial last beat, column carries
  wig_harness #(.WIN(3), .LANES(4), .NX(8), .NY(6), .DX(40), .DY(-24),
                .X0(1000), .Y0(-300), .CRD_W(20)) h_a (.clk(clk), .done(done_a));

  // two-wide window over five lanes: one beat per centre, one idle lane
  wig_harness #(.WIN(2), .LANES(5), .NX(5), .NY(4), .DX(7), .DY(9),
                .X0(-5), .Y0(12), .CRD_W(20)) h_b (.clk(clk), .done(done_b));

  initial begin
    int passed, total;
    fork
      wait (done_a === 1'b1 && done_b === 1'b1);
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    passed = h_a.npass + h_b.npass;
    total  = passed + h_a.nfail + h_b.nfail;
    if (timed_out) begin
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      total++;
    end
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule